// File: doc/BRIEF.md
# Register File with Pointer Pairs and Data-Space Decode

This block holds the thirty-two 8-bit working registers of a small processor core. Two independent read ports and one write port let an arithmetic unit fetch both operands and store its result in a single clock. The top six registers also act as three 16-bit address pointers. The highest pair also drives a dedicated table-lookup address output, which a program-memory fetch unit can consume.

The block also decodes a flat byte-addressed data space. The lowest thirty-two addresses reach the registers themselves. The next sixty-four addresses go out to an I/O select with a 6-bit local offset. Everything from 0x60 upward goes out to an SRAM select with the full address. Reads are combinational. Writes land on the rising clock edge. Reset is synchronous and active high.

Top module: `gpr_space`

## Requirements
- R1: A clock edge with `rst` high clears all 32 registers to 0x00, and writes presented in that cycle are dropped.
- R2: `rd_a_data` and `rd_b_data` combinationally show the register named by `rd_a_idx` / `rd_b_idx`. A value written through `alu_we` is visible on both ports from the cycle after the edge.
- R3: `ptr_sel` encodes 0 = pointer X (registers 26 low, 27 high), 1 = Y (28, 29), 2 = Z (30, 31), 3 = none. `ptr_rd_data` equals {high register, low register}, or 0x0000 for code 3. A `ptr_we` with code 3 changes no register.
- R4: A `ptr_we` with codes 0 to 2 writes `ptr_wr_data[7:0]` to the even register and `ptr_wr_data[15:8]` to the odd register on the same edge.
- R5: `tbl_ptr` always equals {register 31, register 30}.
- R6: For `ds_addr` 0x0000 to 0x001F, `ds_rdata` shows register `ds_addr[4:0]`, and `ds_we` writes `ds_wdata` there. Neither `io_sel` nor `sram_sel` is raised.
- R7: For `ds_addr` 0x0020 to 0x005F, `io_sel` is high when `ds_re` or `ds_we` is high, `io_we` follows `ds_we`, `io_addr` = `ds_addr` − 0x20, and `ds_rdata` = `io_rdata`. `ext_wdata` always equals `ds_wdata`, and no register changes.
- R8: For `ds_addr` ≥ 0x0060, `sram_sel` is high when `ds_re` or `ds_we` is high, `sram_we` follows `ds_we`, `sram_addr` = `ds_addr`, and `ds_rdata` = `sram_rdata`. No register changes.
- R9: When several writes hit one register on the same edge, the ALU write wins over the pointer write, and the pointer write wins over the data-space write.
- R10: With `ds_re` and `ds_we` both low, `io_sel`, `io_we`, `sram_sel` and `sram_we` are low for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| alu_we | input | 1 | ALU result write enable |
| alu_wr_idx | input | 5 | ALU result destination |
| alu_wr_data | input | 8 | ALU result value |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z, 3 none |
| ptr_we | input | 1 | 16-bit pointer write enable |
| ptr_wr_data | input | 16 | Pointer write value {high, low} |
| ptr_rd_data | output | 16 | Selected pointer value {high, low} |
| tbl_ptr | output | 16 | Table-lookup address, {R31, R30} |
| ds_addr | input | 16 | Data-space byte address |
| ds_re | input | 1 | Data-space read request |
| ds_we | input | 1 | Data-space write request |
| ds_wdata | input | 8 | Data-space write byte |
| ds_rdata | output | 8 | Data-space read byte |
| io_sel | output | 1 | I/O region select |
| io_we | output | 1 | I/O write strobe |
| io_addr | output | 6 | I/O local offset |
| io_rdata | input | 8 | I/O read byte |
| sram_sel | output | 1 | SRAM region select |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | 16 | SRAM byte address |
| sram_rdata | input | 8 | SRAM read byte |
| ext_wdata | output | 8 | Write byte for I/O and SRAM |

## Verification
The commit assertions assume that the indices, the pointer code and the enables are known (not X) at every rising edge. They also assume that a write's effect is judged only when no higher-priority write aims at the same register in that cycle. The bench drives every input at the falling edge from a closed set of legal values, so the first assumption always holds. It exercises colliding writes on purpose, but only in cycles where the reference model, not the commit assertions, predicts the result. Addresses are drawn from all three regions and from the boundary values 0x1F, 0x20, 0x5F and 0x60, so the window assertions see every case.

// File: rtl/gpr_space_pkg.sv
package gpr_space_pkg;

    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        RGN_GPR  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_SRAM = 2'd2
    } region_e;

endpackage

// File: rtl/gpr_space_decode.sv
module gpr_space_decode
    import gpr_space_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 32,
    parameter int IO_SPAN  = 64,
    localparam int IO_AW   = $clog2(IO_SPAN)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              re,
    input  logic              we,
    output region_e           region,
    output logic              io_sel,
    output logic              io_we,
    output logic [IO_AW-1:0]  io_addr,
    output logic              sram_sel,
    output logic              sram_we
);
    localparam logic [ADDR_W-1:0] IO_LO = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] IO_HI = ADDR_W'(NUM_REGS + IO_SPAN);

    logic access;

    always_comb begin
        if (addr < IO_LO)      region = RGN_GPR;
        else if (addr < IO_HI) region = RGN_IO;
        else                   region = RGN_SRAM;
    end

    assign access   = re | we;
    assign io_sel   = access && (region == RGN_IO);
    assign io_we    = we && (region == RGN_IO);
    assign sram_sel = access && (region == RGN_SRAM);
    assign sram_we  = we && (region == RGN_SRAM);
    assign io_addr  = IO_AW'(addr - IO_LO);

endmodule

// File: rtl/gpr_space_wrarb.sv
module gpr_space_wrarb #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       alu_we,
    input  logic [IDX_W-1:0]           alu_idx,
    input  logic [DATA_W-1:0]          alu_data,
    input  logic                       ptr_we,
    input  logic [IDX_W-1:0]           ptr_lo_idx,
    input  logic [2*DATA_W-1:0]        ptr_data,
    input  logic                       ds_we,
    input  logic [IDX_W-1:0]           ds_idx,
    input  logic [DATA_W-1:0]          ds_data,
    output logic [NUM_REGS-1:0]        wen,
    output logic [NUM_REGS*DATA_W-1:0] wval
);
    logic [IDX_W-1:0] ptr_hi_idx;
    assign ptr_hi_idx = ptr_lo_idx + IDX_W'(1);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam bit ODD = (g % 2) == 1;
        logic alu_hit, ptr_hit, ds_hit;
        logic [DATA_W-1:0] ptr_byte;

        assign alu_hit  = alu_we && (alu_idx == IDX_W'(g));
        assign ptr_hit  = ptr_we && ((ODD ? ptr_hi_idx : ptr_lo_idx) == IDX_W'(g));
        assign ds_hit   = ds_we && (ds_idx == IDX_W'(g));
        assign ptr_byte = ODD ? ptr_data[2*DATA_W-1:DATA_W] : ptr_data[DATA_W-1:0];

        assign wen[g] = alu_hit | ptr_hit | ds_hit;
        assign wval[g*DATA_W +: DATA_W] = alu_hit ? alu_data :
                                          ptr_hit ? ptr_byte : ds_data;
    end

endmodule

// File: rtl/gpr_space_store.sv
module gpr_space_store #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REGS-1:0]        wen,
    input  logic [NUM_REGS*DATA_W-1:0] wval,
    output logic [NUM_REGS*DATA_W-1:0] q_flat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_flat <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wen[i]) q_flat[i*DATA_W +: DATA_W] <= wval[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/gpr_space.sv
module gpr_space
    import gpr_space_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32,
    parameter int IO_SPAN  = 64,
    parameter int ADDR_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int IO_AW   = $clog2(IO_SPAN),
    localparam int PTR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              alu_we,
    input  logic [IDX_W-1:0]  alu_wr_idx,
    input  logic [DATA_W-1:0] alu_wr_data,
    input  logic [1:0]        ptr_sel,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_wr_data,
    output logic [PTR_W-1:0]  ptr_rd_data,
    output logic [PTR_W-1:0]  tbl_ptr,
    input  logic [ADDR_W-1:0] ds_addr,
    input  logic              ds_re,
    input  logic              ds_we,
    input  logic [DATA_W-1:0] ds_wdata,
    output logic [DATA_W-1:0] ds_rdata,
    output logic              io_sel,
    output logic              io_we,
    output logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              sram_sel,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic [DATA_W-1:0] ext_wdata
);
    localparam int PTR_BASE = NUM_REGS - 6;

    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic [NUM_REGS-1:0]        wen;
    logic [NUM_REGS*DATA_W-1:0] wval;
    region_e                    region;
    ptr_sel_e                   psel;
    logic                       ptr_valid;
    logic [IDX_W-1:0]           ptr_lo_idx;
    logic [IDX_W-1:0]           ptr_hi_idx;
    logic [IDX_W-1:0]           ds_idx;

    assign psel       = ptr_sel_e'(ptr_sel);
    assign ptr_valid  = (psel != PTR_NONE);
    assign ptr_lo_idx = IDX_W'(PTR_BASE) + IDX_W'({ptr_sel, 1'b0});
    assign ptr_hi_idx = ptr_lo_idx + IDX_W'(1);
    assign ds_idx     = ds_addr[IDX_W-1:0];

    gpr_space_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IO_SPAN(IO_SPAN)
    ) u_decode (
        .addr(ds_addr), .re(ds_re), .we(ds_we), .region(region),
        .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr),
        .sram_sel(sram_sel), .sram_we(sram_we)
    );

    gpr_space_wrarb #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
    ) u_wrarb (
        .alu_we(alu_we), .alu_idx(alu_wr_idx), .alu_data(alu_wr_data),
        .ptr_we(ptr_we && ptr_valid), .ptr_lo_idx(ptr_lo_idx), .ptr_data(ptr_wr_data),
        .ds_we(ds_we && (region == RGN_GPR)), .ds_idx(ds_idx), .ds_data(ds_wdata),
        .wen(wen), .wval(wval)
    );

    gpr_space_store #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
    ) u_store (
        .clk(clk), .rst(rst), .wen(wen), .wval(wval), .q_flat(regs_flat)
    );

    assign rd_a_data = regs_flat[rd_a_idx*DATA_W +: DATA_W];
    assign rd_b_data = regs_flat[rd_b_idx*DATA_W +: DATA_W];
    assign tbl_ptr   = regs_flat[(NUM_REGS-2)*DATA_W +: PTR_W];
    assign sram_addr = ds_addr;
    assign ext_wdata = ds_wdata;

    always_comb begin
        if (ptr_valid)
            ptr_rd_data = {regs_flat[ptr_hi_idx*DATA_W +: DATA_W],
                           regs_flat[ptr_lo_idx*DATA_W +: DATA_W]};
        else
            ptr_rd_data = '0;
    end

    always_comb begin
        unique case (region)
            RGN_GPR:  ds_rdata = regs_flat[ds_idx*DATA_W +: DATA_W];
            RGN_IO:   ds_rdata = io_rdata;
            RGN_SRAM: ds_rdata = sram_rdata;
            default:  ds_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpr_space_checks.sv
module gpr_space_checks #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32,
    parameter int IO_SPAN  = 64,
    parameter int ADDR_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int IO_AW   = $clog2(IO_SPAN),
    localparam int PTR_W   = 2 * DATA_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       alu_we,
    input logic [IDX_W-1:0]           alu_wr_idx,
    input logic [DATA_W-1:0]          alu_wr_data,
    input logic [1:0]                 ptr_sel,
    input logic                       ptr_we,
    input logic [PTR_W-1:0]           ptr_wr_data,
    input logic [PTR_W-1:0]           tbl_ptr,
    input logic [ADDR_W-1:0]          ds_addr,
    input logic                       ds_re,
    input logic                       ds_we,
    input logic [DATA_W-1:0]          ds_wdata,
    input logic                       io_sel,
    input logic                       io_we,
    input logic [IO_AW-1:0]           io_addr,
    input logic                       sram_sel,
    input logic                       sram_we,
    input logic [ADDR_W-1:0]          sram_addr,
    input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(NUM_REGS + IO_SPAN);
    localparam logic [IDX_W-1:0]  PB = IDX_W'(NUM_REGS - 6);

    function automatic logic [DATA_W-1:0] reg_at(input logic [IDX_W-1:0] i);
        return regs_flat[i*DATA_W +: DATA_W];
    endfunction

    logic              rst_d   = 1'b0;
    logic              alu_q   = 1'b0;
    logic [IDX_W-1:0]  alu_i_q = '0;
    logic [DATA_W-1:0] alu_d_q = '0;
    logic              ptr_q   = 1'b0;
    logic [IDX_W-1:0]  ptr_i_q = '0;
    logic [PTR_W-1:0]  ptr_d_q = '0;
    logic              ds_q    = 1'b0;
    logic [IDX_W-1:0]  ds_i_q  = '0;
    logic [DATA_W-1:0] ds_d_q  = '0;
    logic              ptr_ok;

    assign ptr_ok = ptr_we && (ptr_sel != 2'd3);

    always_ff @(posedge clk) begin
        rst_d   <= rst;
        alu_q   <= alu_we && !rst;
        alu_i_q <= alu_wr_idx;
        alu_d_q <= alu_wr_data;
        ptr_q   <= ptr_ok && !alu_we && !rst;
        ptr_i_q <= PB + IDX_W'({ptr_sel, 1'b0});
        ptr_d_q <= ptr_wr_data;
        ds_q    <= ds_we && (ds_addr < LO) && !alu_we && !ptr_ok && !rst;
        ds_i_q  <= ds_addr[IDX_W-1:0];
        ds_d_q  <= ds_wdata;
    end

    always @(negedge clk) begin
        if (rst_d) begin
            assert_reset_clear_R1: assert (regs_flat == '0);
        end
    end

    assert_alu_commit_R9: assert property (@(posedge clk) disable iff (rst)
        alu_q |-> reg_at(alu_i_q) == alu_d_q);

    assert_ptr_pair_R4: assert property (@(posedge clk) disable iff (rst)
        ptr_q |-> {reg_at(ptr_i_q + IDX_W'(1)), reg_at(ptr_i_q)} == ptr_d_q);

    assert_ds_commit_R6: assert property (@(posedge clk) disable iff (rst)
        ds_q |-> reg_at(ds_i_q) == ds_d_q);

    assert_tbl_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        tbl_ptr == {reg_at(IDX_W'(NUM_REGS-1)), reg_at(IDX_W'(NUM_REGS-2))});

    assert_io_window_R7: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> (ds_addr >= LO) && (ds_addr < HI) && (ADDR_W'(io_addr) + LO == ds_addr));

    assert_io_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        io_we |-> io_sel && ds_we);

    assert_sram_window_R8: assert property (@(posedge clk) disable iff (rst)
        sram_sel |-> (ds_addr >= HI) && (sram_addr == ds_addr));

    assert_sram_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> sram_sel && ds_we);

    assert_one_target_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_sel, sram_sel}));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(ds_re || ds_we) |-> !io_sel && !sram_sel);

endmodule

bind gpr_space gpr_space_checks #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IO_SPAN(IO_SPAN), .ADDR_W(ADDR_W)
) u_checks (.*);

// File: tb/gpr_space_test.sv
`timescale 1ns/1ps
module gpr_space_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, alu_wr_idx = '0;
    logic [7:0]  rd_a_data, rd_b_data;
    logic        alu_we = 1'b0;
    logic [7:0]  alu_wr_data = '0;
    logic [1:0]  ptr_sel = '0;
    logic        ptr_we = 1'b0;
    logic [15:0] ptr_wr_data = '0;
    logic [15:0] ptr_rd_data, tbl_ptr;
    logic [15:0] ds_addr = '0;
    logic        ds_re = 1'b0, ds_we = 1'b0;
    logic [7:0]  ds_wdata = '0, ds_rdata;
    logic        io_sel, io_we, sram_sel, sram_we;
    logic [5:0]  io_addr;
    logic [7:0]  io_rdata = 8'h5A, sram_rdata = 8'hC3, ext_wdata;
    logic [15:0] sram_addr;

    logic [7:0] model [0:31];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gpr_space uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .alu_we(alu_we), .alu_wr_idx(alu_wr_idx), .alu_wr_data(alu_wr_data),
        .ptr_sel(ptr_sel), .ptr_we(ptr_we), .ptr_wr_data(ptr_wr_data),
        .ptr_rd_data(ptr_rd_data), .tbl_ptr(tbl_ptr),
        .ds_addr(ds_addr), .ds_re(ds_re), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr),
        .io_rdata(io_rdata), .sram_sel(sram_sel), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_rdata(sram_rdata), .ext_wdata(ext_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Combinational expectations from the reference array
    task automatic compare();
        logic [15:0] ep;
        bit acc;
        acc = ds_re | ds_we;
        chk("R2 read port A", rd_a_data, model[rd_a_idx]);
        chk("R2 read port B", rd_b_data, model[rd_b_idx]);
        ep = (ptr_sel == 2'd3) ? 16'h0 : {model[27 + 2*ptr_sel], model[26 + 2*ptr_sel]};
        chk("R3 pointer read", ptr_rd_data, ep);
        chk("R5 table pointer", tbl_ptr, {model[31], model[30]});
        chk("R7 write byte passthrough", ext_wdata, ds_wdata);
        if (ds_addr < 16'h20) begin
            chk("R6 register read", ds_rdata, model[ds_addr[4:0]]);
            chk("R6 no strobes", {io_sel, io_we, sram_sel, sram_we}, 0);
        end else if (ds_addr < 16'h60) begin
            chk("R7 io select", io_sel, acc);
            chk("R7 io write", io_we, ds_we);
            chk("R7 io read", ds_rdata, io_rdata);
            chk("R7 no sram", {sram_sel, sram_we}, 0);
            if (acc) chk("R7 io offset", io_addr, ds_addr - 16'h20);
        end else begin
            chk("R8 sram select", sram_sel, acc);
            chk("R8 sram write", sram_we, ds_we);
            chk("R8 sram read", ds_rdata, sram_rdata);
            chk("R8 no io", {io_sel, io_we}, 0);
            if (acc) chk("R8 sram address", sram_addr, ds_addr);
        end
        if (!acc) chk("R10 idle strobes", {io_sel, io_we, sram_sel, sram_we}, 0);
    endtask

    task automatic update_model();
        if (rst) begin
            for (int i = 0; i < 32; i++) model[i] = 8'h00;
        end else begin
            if (ds_we && ds_addr < 16'h20) model[ds_addr[4:0]] = ds_wdata;
            if (ptr_we && ptr_sel != 2'd3) begin
                model[26 + 2*ptr_sel] = ptr_wr_data[7:0];
                model[27 + 2*ptr_sel] = ptr_wr_data[15:8];
            end
            if (alu_we) model[alu_wr_idx] = alu_wr_data;
        end
    endtask

    task automatic cycle();
        #1;
        compare();
        @(posedge clk);
        update_model();
        @(negedge clk);
    endtask

    task automatic idle();
        alu_we = 1'b0; ptr_we = 1'b0; ds_re = 1'b0; ds_we = 1'b0;
    endtask

    task automatic sweep_zero(input string tag);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            #0.1;
            chk(tag, rd_a_data, 8'h00);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        @(posedge clk);
        @(negedge clk);
        cycle();
        rst = 1'b0;
        sweep_zero("R1 register clear after first reset");

        // R2: ALU write, visible next cycle
        alu_we = 1'b1; alu_wr_idx = 5'd5; alu_wr_data = 8'hA5; rd_a_idx = 5'd5; rd_b_idx = 5'd5;
        cycle();
        idle();
        #1 chk("R2 alu write visible", rd_b_data, 8'hA5);
        cycle();

        // R4: pointer writes
        for (int s = 0; s < 3; s++) begin
            ptr_sel = 2'(s); ptr_we = 1'b1; ptr_wr_data = 16'h1234 + 16'(s) * 16'h4444;
            cycle();
        end
        idle();
        for (int s = 0; s < 3; s++) begin
            ptr_sel = 2'(s);
            #1 chk("R4 pointer pair readback", ptr_rd_data, 16'h1234 + 16'(s) * 16'h4444);
        end
        chk("R5 table pointer equals Z", tbl_ptr, 16'h9ABC);
        rd_a_idx = 5'd26;
        #1 chk("R4 low byte in even register", rd_a_data, 8'h34);

        // R3: code 3 reads zero and ignores writes
        ptr_sel = 2'd3; ptr_we = 1'b1; ptr_wr_data = 16'hFFFF;
        cycle();
        idle();
        #1 chk("R3 no-pointer read", ptr_rd_data, 16'h0000);
        ptr_sel = 2'd1;
        #1 chk("R3 write with code 3 ignored", ptr_rd_data, 16'h5678);
        cycle();

        // R6: data-space register access
        ds_we = 1'b1; ds_addr = 16'h0007; ds_wdata = 8'h3C;
        cycle();
        idle(); ds_re = 1'b1;
        #1 chk("R6 data-space write landed", ds_rdata, 8'h3C);
        ds_addr = 16'h001F;
        cycle();

        // R7: I/O window and boundaries
        ds_re = 1'b0; ds_we = 1'b1; ds_addr = 16'h0020; ds_wdata = 8'h77;
        #1 chk("R7 io lower bound", {io_sel, io_we, io_addr}, {2'b11, 6'd0});
        cycle();
        ds_addr = 16'h005F;
        #1 chk("R7 io upper bound", io_addr, 6'd63);
        cycle();
        idle(); ds_re = 1'b1; ds_addr = 16'h0025; io_rdata = 8'h99;
        #1 chk("R7 io read data", ds_rdata, 8'h99);
        cycle();

        // R8: SRAM region
        ds_addr = 16'h0060; sram_rdata = 8'h42;
        #1 chk("R8 sram lower bound", {sram_sel, sram_addr}, {1'b1, 16'h0060});
        cycle();
        ds_re = 1'b0; ds_we = 1'b1; ds_addr = 16'hBEEF;
        cycle();

        // R9: three writers on one register
        idle();
        alu_we = 1'b1; alu_wr_idx = 5'd30; alu_wr_data = 8'h11;
        ptr_we = 1'b1; ptr_sel = 2'd2; ptr_wr_data = 16'h2233;
        ds_we = 1'b1; ds_addr = 16'h001E; ds_wdata = 8'h44;
        cycle();
        idle(); rd_a_idx = 5'd30; rd_b_idx = 5'd31;
        #1 chk("R9 alu beats pointer and data space", rd_a_data, 8'h11);
        chk("R9 pointer beats data space", rd_b_data, 8'h22);
        ptr_we = 1'b1; ptr_sel = 2'd0; ptr_wr_data = 16'hAA55;
        ds_we = 1'b1; ds_addr = 16'h001A; ds_wdata = 8'h01;
        cycle();
        idle(); rd_a_idx = 5'd26;
        #1 chk("R9 pointer beats data space low byte", rd_a_data, 8'h55);

        // R10: idle strobes across regions
        ds_addr = 16'h0030;
        #1 chk("R10 idle in io window", {io_sel, sram_sel}, 0);
        cycle();
        ds_addr = 16'h0100;
        #1 chk("R10 idle in sram window", {io_sel, sram_sel}, 0);
        cycle();

        // Mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int pick;
            rst         = ($urandom_range(0, 299) == 0);
            rd_a_idx    = 5'($urandom);
            rd_b_idx    = 5'($urandom);
            alu_we      = ($urandom_range(0, 2) == 0);
            alu_wr_idx  = 5'($urandom);
            alu_wr_data = 8'($urandom);
            ptr_sel     = 2'($urandom);
            ptr_we      = ($urandom_range(0, 3) == 0);
            ptr_wr_data = 16'($urandom);
            ds_re       = $urandom_range(0, 1) == 1;
            ds_we       = $urandom_range(0, 2) == 0;
            ds_wdata    = 8'($urandom);
            io_rdata    = 8'($urandom);
            sram_rdata  = 8'($urandom);
            pick = $urandom_range(0, 9);
            if (pick < 5)       ds_addr = 16'($urandom_range(0, 31));
            else if (pick < 7)  ds_addr = 16'($urandom_range(32, 95));
            else if (pick < 8)  ds_addr = 16'($urandom);
            else begin
                case ($urandom_range(0, 3))
                    0: ds_addr = 16'h001F;
                    1: ds_addr = 16'h0020;
                    2: ds_addr = 16'h005F;
                    default: ds_addr = 16'h0060;
                endcase
            end
            cycle();
        end

        // R1: reset with writes pending clears everything
        idle();
        rst = 1'b1;
        alu_we = 1'b1; alu_wr_idx = 5'd3; alu_wr_data = 8'hEE;
        cycle();
        rst = 1'b0; idle();
        sweep_zero("R1 register clear with write pending");
        cycle();

        summary();
    end

endmodule